// File: doc/BRIEF.md
# SPI Register Bank Slave with Configurable Pointer and Interrupt Pin

This block is the serial front end of a small port-expander peripheral. A host reaches it over a mode 0 SPI link. Each transaction has three parts: a control byte that names the device and the direction, a byte that loads the register pointer, and then any number of data bytes until chip select goes high. The block holds eleven byte-wide registers at addresses 0x00 to 0x0A. Writes store into the register the pointer selects. Reads shift that register out on MISO, most significant bit first.

The register at 0x05 configures the block. One bit chooses whether the pointer steps after each data byte or stays fixed, which lets a host poll a single register without resending its address. A second bit decides whether the two strap inputs take part in selecting the device. Two further bits set how the interrupt pin is driven: open-drain, or push-pull at a chosen polarity. The interrupt condition itself arrives from neighbouring logic as a plain request level.

SCK, chip select and MOSI are sampled through synchronisers in the system clock domain. The system clock must therefore run well above the bit rate.

Top module: `spi_regptr_slave`

## Requirements
- R1: After reset every register reads 0x00, `miso_oe` is low, and the interrupt pin is push-pull active-low (`int_oe`=1, `int_pin`=NOT `irq_req`).
- R2: The configuration register is at address 0x05. Bits 7, 6 and 0 always read 0. Bits 5 to 1 keep the value written to them.
- R3: With configuration bit 5 at 0, the pointer steps by one after every data byte, and it wraps from 0x0A to 0x00.
- R4: With configuration bit 5 at 1, the pointer stays put, so every data byte of a burst reads or writes the same register.
- R5: With configuration bit 3 at 1, control byte bits 2:1 must equal `hw_addr`. On a mismatch the frame writes nothing and `miso_oe` stays low.
- R6: With configuration bit 3 at 0, `hw_addr` plays no part in selection.
- R7: A control byte whose bits 7:4 differ from 0100 is ignored whatever the other bits hold. Bit 0 of the control byte is the direction, with 1 meaning read.
- R8: With configuration bit 2 at 1, `int_pin` is 0, and `int_oe` follows `irq_req`, so the pin is released while no interrupt is pending. Bit 1 then has no effect.
- R9: With configuration bit 2 at 0, `int_oe` is 1 and `int_pin` equals `irq_req` when bit 1 is 1, or its inverse when bit 1 is 0.
- R10: Configuration bit 4 stores and reads back, and it changes neither pointer nor pin behaviour.
- R11: Pointer values 0x0B to 0xFF read as 0x00 and drop writes. Stepping from any of them gives 0x00.
- R12: Read data leaves MSB-first. It changes after SCK falls and is valid for the rising edge. `miso_oe` is high only in the data phase of a selected read frame. A configuration write in a burst applies from the next byte onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for MISO |
| hw_addr | input | 2 | Strap address inputs |
| irq_req | input | 1 | Interrupt request level from internal logic |
| int_pin | output | 1 | Interrupt pin data value |
| int_oe | output | 1 | Interrupt pin drive enable |

## Verification
The assertions assume that SCK and chip select change slowly compared with the system clock. Each SCK phase must last long enough that a byte completes, and the pointer settles, before the next opposite edge reaches the synchronisers. They also assume that chip select goes high only with SCK low. The bench keeps to this by holding every SCK half-period at eight system clocks and by toggling chip select only between bytes. Its random frames vary the control byte, the start address, the burst length and the data, configuration writes included. The strap inputs change only between frames.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  localparam int DW = 8;
  localparam logic [3:0] CTRL_TAG = 4'b0100;
  localparam logic [DW-1:0] CFG_MASK = 8'b0011_1110;

  typedef enum logic [1:0] {FS_CTRL, FS_ADDR, FS_DATA, FS_SKIP} frame_st_e;

  typedef struct packed {
    logic seq_hold;
    logic haen;
    logic odr;
    logic pol;
  } cfg_t;
endpackage

// File: rtl/spi_rp_shift.sv
module spi_rp_shift
  import spi_rp_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  input  logic [DW-1:0] tx_byte,
  input  logic          tx_load,
  output logic          cs_act,
  output logic          byte_vld,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int BW = $clog2(DW);

  logic [SYNC-1:0] cs_p, sck_p, mo_p;
  logic            sck_d;
  logic            cs_s, sck_s, mosi_s, rise, fall;
  logic [BW-1:0]   bit_q, bit_d;
  logic [DW-1:0]   rx_q, rx_d, tx_q, tx_d;
  logic            pend_q, pend_d, vld_q, vld_d;

  assign cs_s   = cs_p[SYNC-1];
  assign sck_s  = sck_p[SYNC-1];
  assign mosi_s = mo_p[SYNC-1];
  assign rise   = sck_s & ~sck_d & ~cs_s;
  assign fall   = ~sck_s & sck_d & ~cs_s;

  always_comb begin
    bit_d  = bit_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    pend_d = pend_q | tx_load;
    vld_d  = 1'b0;
    if (cs_s) begin
      bit_d  = '0;
      pend_d = 1'b0;
      tx_d   = '0;
    end else begin
      if (rise) begin
        rx_d  = {rx_q[DW-2:0], mosi_s};
        bit_d = bit_q + 1'b1;
        vld_d = (bit_q == BW'(DW-1));
      end
      if (fall) begin
        if (pend_q) begin
          tx_d   = tx_byte;
          pend_d = tx_load;
        end else begin
          tx_d = {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= '1;
      sck_p  <= '0;
      mo_p   <= '0;
      sck_d  <= 1'b0;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      cs_p   <= {cs_p[SYNC-2:0], cs_n};
      sck_p  <= {sck_p[SYNC-2:0], sck};
      mo_p   <= {mo_p[SYNC-2:0], mosi};
      sck_d  <= sck_s;
      bit_q  <= bit_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      pend_q <= pend_d;
      vld_q  <= vld_d;
    end
  end

  assign cs_act   = ~cs_s;
  assign byte_vld = vld_q;
  assign rx_byte  = rx_q;
  assign miso     = tx_q[DW-1];

  // R12: a completed byte is a single-cycle strobe
  p_strobe_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);
endmodule

// File: rtl/spi_rp_frame.sv
module spi_rp_frame
  import spi_rp_pkg::*;
#(
  parameter int NREG = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          byte_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic [1:0]    hw_addr,
  input  cfg_t          cfg,
  output logic [DW-1:0] ptr,
  output logic          wr_en,
  output logic          tx_load,
  output logic          miso_oe
);
  localparam logic [DW-1:0] LAST = DW'(NREG - 1);

  frame_st_e     st_q, st_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic          rd_q, rd_d;
  logic          sel;

  assign sel = (rx_byte[7:4] == CTRL_TAG) && (!cfg.haen || rx_byte[2:1] == hw_addr);

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    rd_d    = rd_q;
    wr_en   = 1'b0;
    tx_load = 1'b0;
    if (!cs_act) begin
      st_d = FS_CTRL;
    end else if (byte_vld) begin
      case (st_q)
        FS_CTRL: begin
          st_d = sel ? FS_ADDR : FS_SKIP;
          rd_d = rx_byte[0];
        end
        FS_ADDR: begin
          ptr_d   = rx_byte;
          st_d    = FS_DATA;
          tx_load = rd_q;
        end
        FS_DATA: begin
          wr_en   = !rd_q;
          tx_load = rd_q;
          if (!cfg.seq_hold) ptr_d = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_CTRL;
      ptr_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      rd_q  <= rd_d;
    end
  end

  assign ptr     = ptr_q;
  assign miso_oe = cs_act && (st_q == FS_DATA) && rd_q;

  // R3: stepping past the last register lands on 0x00
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_vld && st_q == FS_DATA && !cfg.seq_hold && ptr_q == LAST) |=> ptr_q == '0);
  // R4: a held pointer survives a data byte
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_vld && st_q == FS_DATA && cfg.seq_hold) |=> $stable(ptr_q));
  // R5: an unselected frame neither drives nor writes
  p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FS_SKIP) |-> (!miso_oe && !wr_en));
endmodule

// File: rtl/spi_rp_regs.sv
module spi_rp_regs
  import spi_rp_pkg::*;
#(
  parameter int NREG     = 11,
  parameter int CFG_ADDR = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output cfg_t          cfg
);
  logic [DW-1:0] reg_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] MASK = (i == CFG_ADDR) ? CFG_MASK : '1;
    logic          hit;
    logic [DW-1:0] nxt;
    always_comb begin
      hit = wr_en && (addr == DW'(i));
      nxt = hit ? (wdata & MASK) : reg_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q[i] <= '0;
      else        reg_q[i] <= nxt;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == DW'(i)) rdata = reg_q[i];
    end
  end

  assign cfg.seq_hold = reg_q[CFG_ADDR][5];
  assign cfg.haen     = reg_q[CFG_ADDR][3];
  assign cfg.odr      = reg_q[CFG_ADDR][2];
  assign cfg.pol      = reg_q[CFG_ADDR][1];

  // R2: unimplemented configuration bits read as zero
  p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == DW'(CFG_ADDR)) |-> ((rdata & ~CFG_MASK) == '0));
  // R11: out-of-range pointer reads zero
  p_oob_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= DW'(NREG)) |-> (rdata == '0));
endmodule

// File: rtl/spi_rp_intfmt.sv
module spi_rp_intfmt
  import spi_rp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  logic irq_req,
  output logic int_pin,
  output logic int_oe
);
  logic pin_q, pin_d, oe_q, oe_d;

  always_comb begin
    if (cfg.odr) begin
      pin_d = 1'b0;
      oe_d  = irq_req;
    end else begin
      oe_d  = 1'b1;
      pin_d = cfg.pol ? irq_req : ~irq_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign int_pin = pin_q;
  assign int_oe  = oe_q;

  // R8: open-drain mode never drives high
  p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.odr) |-> !int_pin);
  // R9: push-pull mode always drives
  p_pp_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg.odr) |-> int_oe);
endmodule

// File: rtl/spi_regptr_slave.sv
module spi_regptr_slave
  import spi_rp_pkg::*;
#(
  parameter int NREG     = 11,
  parameter int CFG_ADDR = 5,
  parameter int SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic [1:0] hw_addr,
  input  logic       irq_req,
  output logic       int_pin,
  output logic       int_oe
);
  logic          cs_act, byte_vld, tx_load, wr_en;
  logic [DW-1:0] rx_byte, ptr, rdata;
  cfg_t          cfg;

  spi_rp_shift #(.SYNC(SYNC)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .tx_byte(rdata), .tx_load(tx_load), .cs_act(cs_act),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .miso(miso)
  );

  spi_rp_frame #(.NREG(NREG)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_vld(byte_vld),
    .rx_byte(rx_byte), .hw_addr(hw_addr), .cfg(cfg), .ptr(ptr),
    .wr_en(wr_en), .tx_load(tx_load), .miso_oe(miso_oe)
  );

  spi_rp_regs #(.NREG(NREG), .CFG_ADDR(CFG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr),
    .wdata(rx_byte), .rdata(rdata), .cfg(cfg)
  );

  spi_rp_intfmt u_int (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .irq_req(irq_req),
    .int_pin(int_pin), .int_oe(int_oe)
  );

  // R12: MISO is enabled only while a frame is open
  p_oe_in_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> cs_act);
endmodule

// File: tb/spi_regptr_slave_bench.sv
module spi_regptr_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [1:0] hw_addr = 2'b10;
  logic irq_req = 1'b0;
  logic miso, miso_oe, int_pin, int_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit [7:0] mdl [11];
  bit [7:0] tbuf [8];
  bit [7:0] rbuf [8];

  always #4 clk = ~clk;

  spi_regptr_slave u_spi_regptr_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .hw_addr(hw_addr), .irq_req(irq_req),
    .int_pin(int_pin), .int_oe(int_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] mdl_rd(input int p);
    return (p < 11) ? mdl[p] : 8'h00;
  endfunction

  task automatic xfer(input bit [7:0] tx, output bit [7:0] rx, output bit oe0, output bit oe1);
    oe0 = 1'b0; oe1 = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      if (miso_oe) oe1 = 1'b1; else oe0 = 1'b1;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sck = 1'b0;
  endtask

  task automatic frame(input bit [7:0] ctrl, input bit [7:0] addr, input int n, input string tag);
    bit [7:0] rx;
    bit o0, o1, any1, dat0;
    bit sel, rd, hold;
    int p;
    any1 = 1'b0; dat0 = 1'b0;
    sel = (ctrl[7:4] == 4'b0100) && (!mdl[5][3] || ctrl[2:1] == hw_addr);
    rd  = ctrl[0];
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    xfer(ctrl, rx, o0, o1); any1 |= o1;
    xfer(addr, rx, o0, o1); any1 |= o1;
    for (int k = 0; k < n; k++) begin
      xfer(tbuf[k], rbuf[k], o0, o1);
      any1 |= o1; dat0 |= o0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
    if (sel && rd) chk(!dat0, {tag, " R12 oe in read data"}, 0, 1);
    else           chk(!any1, {tag, " R12 oe quiet"}, 1, 0);
    if (sel) begin
      p = addr;
      for (int k = 0; k < n; k++) begin
        hold = mdl[5][5];
        if (rd) chk(rbuf[k] == mdl_rd(p), {tag, " read byte"}, rbuf[k], mdl_rd(p));
        else if (p < 11) mdl[p] = (p == 5) ? (tbuf[k] & 8'h3E) : tbuf[k];
        if (!hold) p = (p >= 10) ? 0 : p + 1;
      end
    end
  endtask

  task automatic int_chk(input bit req, input string tag);
    bit ep, eo;
    @(negedge clk); irq_req = req;
    repeat (3) @(negedge clk);
    if (mdl[5][2]) begin ep = 1'b0; eo = req; end
    else begin eo = 1'b1; ep = mdl[5][1] ? req : ~req; end
    chk(int_pin == ep && int_oe == eo, tag, {int_pin, int_oe}, {ep, eo});
  endtask

  task automatic wr1(input bit [7:0] ctrl, input bit [7:0] a, input bit [7:0] d, input string tag);
    tbuf[0] = d;
    frame(ctrl, a, 1, tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 11; i++) mdl[i] = 8'h00;
    for (int i = 0; i < 8; i++) tbuf[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(miso_oe == 1'b0, "R1 miso_oe", miso_oe, 0);
    chk(int_oe == 1'b1 && int_pin == 1'b1, "R1 int pin", {int_pin, int_oe}, 2'b11);
    frame(8'h41, 8'h00, 8, "R1");
    frame(8'h41, 8'h08, 3, "R1");
    // R2 config mask
    wr1(8'h40, 8'h05, 8'hFF, "R2");
    frame(8'h45, 8'h05, 1, "R2");
    chk(rbuf[0] == 8'h3E, "R2 cfg mask", rbuf[0], 8'h3E);
    // R8 open-drain
    int_chk(1'b0, "R8 od idle");
    int_chk(1'b1, "R8 od active");
    // R4 held pointer
    tbuf[0] = 8'hA1; tbuf[1] = 8'hB2; tbuf[2] = 8'hC3;
    frame(8'h44, 8'h02, 3, "R4");
    frame(8'h45, 8'h02, 3, "R4");
    chk(rbuf[2] == 8'hC3 && rbuf[0] == 8'hC3, "R4 same reg", rbuf[0], 8'hC3);
    chk(rbuf[1] == 8'hC3, "R4 same reg mid", rbuf[1], 8'hC3);
    // R5 address pins enforced
    wr1(8'h40, 8'h03, 8'h5A, "R5");
    frame(8'h43, 8'h03, 2, "R5");
    frame(8'h45, 8'h03, 1, "R5");
    chk(rbuf[0] == 8'h00, "R5 write dropped", rbuf[0], 0);
    // R7 bad fixed nibble
    wr1(8'h64, 8'h03, 8'h77, "R7");
    frame(8'h45, 8'h03, 1, "R7");
    chk(rbuf[0] == 8'h00, "R7 ignored", rbuf[0], 0);
    // R9 push-pull, active-high then active-low
    wr1(8'h44, 8'h05, 8'h02, "R9");
    int_chk(1'b1, "R9 pol high act");
    int_chk(1'b0, "R9 pol high idle");
    wr1(8'h40, 8'h05, 8'h00, "R9");
    int_chk(1'b1, "R9 pol low act");
    int_chk(1'b0, "R9 pol low idle");
    // R6 pins ignored
    hw_addr = 2'b01;
    wr1(8'h46, 8'h03, 8'h3C, "R6");
    frame(8'h43, 8'h03, 1, "R6");
    chk(rbuf[0] == 8'h3C, "R6 pins ignored", rbuf[0], 8'h3C);
    // R3 increment and wrap
    tbuf[0] = 8'h19; tbuf[1] = 8'h1A; tbuf[2] = 8'h10; tbuf[3] = 8'h11;
    frame(8'h40, 8'h09, 4, "R3");
    frame(8'h41, 8'h09, 4, "R3");
    chk(rbuf[2] == 8'h10 && rbuf[1] == 8'h1A, "R3 wrap", rbuf[2], 8'h10);
    // R11 out of range
    wr1(8'h40, 8'h0C, 8'h77, "R11");
    frame(8'h41, 8'h0B, 3, "R11");
    chk(rbuf[0] == 8'h00 && rbuf[1] == 8'h10, "R11 oob", rbuf[1], 8'h10);
    // R10 storage bit
    wr1(8'h40, 8'h05, 8'h10, "R10");
    frame(8'h41, 8'h05, 2, "R10");
    chk(rbuf[0] == 8'h10, "R10 readback", rbuf[0], 8'h10);
    int_chk(1'b1, "R10 pin unaffected");
    // R12 mid-burst config write
    tbuf[0] = 8'h11; tbuf[1] = 8'h20; tbuf[2] = 8'h33; tbuf[3] = 8'h44;
    frame(8'h40, 8'h04, 4, "R12");
    frame(8'h41, 8'h06, 2, "R12");
    chk(rbuf[0] == 8'h44, "R12 hold from next byte", rbuf[0], 8'h44);
    wr1(8'h40, 8'h05, 8'h00, "R12");
    // random frames
    void'($urandom(32'd1234));
    for (int f = 0; f < 40; f++) begin
      bit [7:0] c;
      int n;
      c = {4'b0100, 2'($urandom_range(0, 3)), 1'b0, 1'($urandom_range(0, 1))};
      if ($urandom_range(0, 7) == 0) c[7:4] = 4'($urandom_range(0, 15));
      n = $urandom_range(1, 5);
      for (int k = 0; k < 8; k++) tbuf[k] = 8'($urandom_range(0, 255));
      hw_addr = 2'($urandom_range(0, 3));
      frame(c, 8'($urandom_range(0, 12)), n, "rand R3 R4 R5 R6");
      int_chk(1'($urandom_range(0, 1)), "rand R8 R9");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule